// File: doc/BRIEF.md
# PCI Even-Parity Generator and Target Write Checker

This block sits next to the AD and C/BE# pads of a PCI port. Every clock it folds the 36 bits of the address/data word and the command/byte-enable nibble into one parity bit. It presents that bit, together with its own drive enable, one clock later. That is the clock in which the bus expects PAR for the phase that has just passed. The drive enable is the AD output enable, delayed by one register, so PAR is driven in exactly the cycles that follow AD drive cycles. Those are the address phase of transactions the device initiates, the data phases of writes it initiates, and the data phases of reads it answers as a target.

When the device is the target of a write, the block watches the IRDY#/TRDY# handshake. For each completed data phase it keeps the locally computed parity. On the next clock it compares that value with the PAR value received from the bus. A mismatch sets a sticky error flag, and a write-one-to-clear strobe resets the flag. An interrupt request follows the flag, gated by an enable input. All outputs are registered and cleared by a synchronous active-high reset.

Top module: `pci_parity_unit`

## Requirements
- R1: `par_o` is the XOR of all 32 AD bits and all 4 C/BE# bits, so the 36 bits plus PAR hold an even number of ones, whatever the byte-enable values are.
- R2: `par_o` after a rising edge reflects the AD/C/BE# values sampled at the previous rising edge (one clock of latency).
- R3: `par_oe_o` equals `ad_oe_i` sampled at the previous rising edge.
- R4: A data phase is checked only when, at a rising edge, `is_target_i`=1, `is_write_i`=1, `irdy_n_i`=0 and `trdy_n_i`=0. Its parity is compared with `par_i` sampled at the next rising edge.
- R5: A mismatch in a checked phase makes `perr_sts_o` read 1 right after the edge at which `par_i` is sampled. A matching PAR leaves the flag at 0.
- R6: `perr_sts_o` is sticky. It returns to 0 only after an edge with `err_clr_i`=1. If a new error is detected at the same edge as the clear, the flag stays 1.
- R7: `irq_o` equals the flag value ANDed with `irq_en_i` at the same edge, so it changes in the same cycle as `perr_sts_o`.
- R8: While `rst` is high at a rising edge, all four outputs become 0.
- R9: A parity mismatch leaves the flag at 0 when the phase is a target read, an initiator write, or a phase where `irdy_n_i` or `trdy_n_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ad_i | input | 32 | AD bus value at the pads |
| cbe_i | input | 4 | C/BE# value at the pads (raw, active-low encoding) |
| ad_oe_i | input | 1 | AD output enable for this cycle |
| par_i | input | 1 | PAR value received from the bus |
| is_target_i | input | 1 | 1 when the device is the target of the current transaction |
| is_write_i | input | 1 | 1 when the current transaction writes toward the target |
| irdy_n_i | input | 1 | IRDY#, active low |
| trdy_n_i | input | 1 | TRDY#, active low |
| err_clr_i | input | 1 | Write-one strobe that clears the error flag |
| irq_en_i | input | 1 | Interrupt enable |
| par_o | output | 1 | Generated parity, one clock behind AD |
| par_oe_o | output | 1 | PAR drive enable, one clock behind the AD enable |
| perr_sts_o | output | 1 | Sticky parity error flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A software clear and a fresh mismatch can reach the error flag at the same rising edge. The bench provokes this by raising `err_clr_i` in the very cycle that a corrupted PAR arrives for a completed target-write phase. It expects the flag and, with the interrupt enabled, `irq_o` to read 1 afterwards. A second clear in a quiet cycle must then bring both to 0. This shows that the earlier 1 was the new error winning and not a clear that was ignored.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;
  localparam int AD_W  = 32;
  localparam int CBE_W = 4;
  localparam int LANE  = 8;

  typedef struct packed {
    logic pend;
    logic parity;
  } chk_stage_t;
endpackage

// File: rtl/pci_par_tree.sv
module pci_par_tree #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4,
  parameter int LANE  = 8
) (
  input  logic [AD_W-1:0]  ad,
  input  logic [CBE_W-1:0] cbe,
  output logic             parity
);
  localparam int NLANE = AD_W / LANE;

  logic [NLANE-1:0] lane_par;

  genvar g;
  generate
    for (g = 0; g < NLANE; g++) begin : g_lane
      assign lane_par[g] = ^ad[g*LANE +: LANE];
    end
  endgenerate

  // Even parity: the parity bit equals the XOR of every covered bit.
  assign parity = (^lane_par) ^ (^cbe);
endmodule

// File: rtl/pci_par_drive.sv
module pci_par_drive (
  input  logic clk,
  input  logic rst,
  input  logic par_now,
  input  logic oe_now,
  output logic par_q,
  output logic oe_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      par_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      par_q <= par_now;
      oe_q  <= oe_now;
    end
  end

  p_oe_follow_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> oe_q == $past(oe_now));
endmodule

// File: rtl/pci_par_check.sv
module pci_par_check
  import pci_par_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic par_now,
  input  logic par_bus,
  input  logic tgt,
  input  logic wr,
  input  logic irdy_n,
  input  logic trdy_n,
  input  logic clr,
  input  logic irq_en,
  output logic sts_q,
  output logic irq_q
);
  chk_stage_t stg;
  logic       hit;
  logic       sts_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg.pend   <= tgt & wr & ~irdy_n & ~trdy_n;
      stg.parity <= par_now;
    end
  end

  assign hit   = stg.pend & (stg.parity ^ par_bus);
  assign sts_d = hit | (sts_q & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      irq_q <= sts_d & irq_en;
    end
  end

  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (sts_q && !clr) |=> sts_q);
  p_set_needs_phase_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(sts_q)) |-> $past(stg.pend));
  p_irq_implies_flag_r7: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> sts_q);
endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit
  import pci_par_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_i,
  input  logic             ad_oe_i,
  input  logic             par_i,
  input  logic             is_target_i,
  input  logic             is_write_i,
  input  logic             irdy_n_i,
  input  logic             trdy_n_i,
  input  logic             err_clr_i,
  input  logic             irq_en_i,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             perr_sts_o,
  output logic             irq_o
);
  logic par_now;

  pci_par_tree #(.AD_W(AD_W), .CBE_W(CBE_W), .LANE(LANE)) u_tree (
    .ad(ad_i), .cbe(cbe_i), .parity(par_now));

  pci_par_drive u_drive (
    .clk(clk), .rst(rst), .par_now(par_now), .oe_now(ad_oe_i),
    .par_q(par_o), .oe_q(par_oe_o));

  pci_par_check u_check (
    .clk(clk), .rst(rst), .par_now(par_now), .par_bus(par_i),
    .tgt(is_target_i), .wr(is_write_i), .irdy_n(irdy_n_i), .trdy_n(trdy_n_i),
    .clr(err_clr_i), .irq_en(irq_en_i), .sts_q(perr_sts_o), .irq_q(irq_o));

  p_even_delayed_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones({$past(ad_i), $past(cbe_i), par_o}) % 2) == 0);
  p_reset_clears_r8: assert property (@(posedge clk)
    $past(rst) |-> !par_o && !par_oe_o && !perr_sts_o && !irq_o);
endmodule

// File: tb/pci_parity_unit_test.sv
module pci_parity_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0]  cbe = '0;
  logic        oe = 1'b0, par_in = 1'b0, tgt = 1'b0, wr = 1'b0;
  logic        irdy_n = 1'b1, trdy_n = 1'b1, clr = 1'b0, ien = 1'b0;
  logic        par_o, par_oe_o, sts, irq;
  int          errors = 0, checks = 0;

  always #2 clk = ~clk;

  pci_parity_unit uut (
    .clk(clk), .rst(rst), .ad_i(ad), .cbe_i(cbe), .ad_oe_i(oe), .par_i(par_in),
    .is_target_i(tgt), .is_write_i(wr), .irdy_n_i(irdy_n), .trdy_n_i(trdy_n),
    .err_clr_i(clr), .irq_en_i(ien), .par_o(par_o), .par_oe_o(par_oe_o),
    .perr_sts_o(sts), .irq_o(irq));

  // {ad, cbe, expected parity}, parities counted by hand
  localparam logic [36:0] TBL [8] = '{
    {32'h0000_0000, 4'h0, 1'b0},
    {32'h0000_0001, 4'h0, 1'b1},
    {32'hFFFF_FFFF, 4'hF, 1'b0},
    {32'hFFFF_FFFF, 4'h0, 1'b0},
    {32'h0000_0000, 4'h1, 1'b1},
    {32'h8000_0000, 4'h7, 1'b0},
    {32'h0000_0007, 4'h0, 1'b1},
    {32'h1234_5678, 4'h0, 1'b1}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Data phase, then PAR cycle (optionally corrupted, optionally with clear).
  task automatic phase(input logic [31:0] a, input logic [3:0] c, input logic t,
                       input logic w, input logic irn, input logic trn,
                       input logic bad, input logic cl);
    @(negedge clk);
    ad = a; cbe = c; tgt = t; wr = w; irdy_n = irn; trdy_n = trn; clr = 1'b0;
    @(negedge clk);
    par_in = (^{a, c}) ^ bad; irdy_n = 1'b1; trdy_n = 1'b1; clr = cl;
    ad = '0; cbe = '0;
    @(negedge clk);
    clr = 1'b0; par_in = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 par", par_o, 1'b0);
    chk("R8 oe", par_oe_o, 1'b0);
    chk("R8 sts", sts, 1'b0);
    chk("R8 irq", irq, 1'b0);
    rst = 1'b0;

    // R1 R2 R3: table walk
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      ad = TBL[i][36:5]; cbe = TBL[i][4:1]; oe = i[0];
      @(negedge clk);
      chk("R1/R2 par", par_o, TBL[i][0]);
      chk("R3 oe", par_oe_o, i[0]);
    end
    oe = 1'b0;

    // R5: good PAR on completed target write
    phase(32'hA5A5_0F0F, 4'h3, 1, 1, 0, 0, 0, 0);
    chk("R5 match keeps flag", sts, 1'b0);

    // R9: mismatches that must be ignored
    phase(32'h1111_2222, 4'h0, 1, 0, 0, 0, 1, 0);
    chk("R9 target read", sts, 1'b0);
    phase(32'h1111_2222, 4'h0, 0, 1, 0, 0, 1, 0);
    chk("R9 initiator write", sts, 1'b0);
    phase(32'h1111_2222, 4'h0, 1, 1, 1, 0, 1, 0);
    chk("R9 irdy high", sts, 1'b0);
    phase(32'h1111_2222, 4'h0, 1, 1, 0, 1, 1, 0);
    chk("R9 trdy high", sts, 1'b0);

    // R4 R5 R7: real mismatch, interrupt disabled; R1 byte enables all off
    phase(32'hDEAD_BEEF, 4'hF, 1, 1, 0, 0, 1, 0);
    chk("R5 mismatch sets flag", sts, 1'b1);
    chk("R7 irq gated off", irq, 1'b0);
    @(negedge clk); ien = 1'b1;
    @(negedge clk);
    chk("R7 irq follows enable", irq, 1'b1);
    repeat (3) @(negedge clk);
    chk("R6 sticky", sts, 1'b1);
    clear_flag();
    chk("R6 cleared", sts, 1'b0);
    chk("R7 irq cleared", irq, 1'b0);

    // R6: clear and new error at the same edge
    phase(32'h0000_00FF, 4'h8, 1, 1, 0, 0, 1, 1);
    chk("R6 set beats clear", sts, 1'b1);
    chk("R7 irq on collision", irq, 1'b1);
    clear_flag();
    chk("R6 later clear", sts, 1'b0);

    // R8: reset drops a set flag
    phase(32'h0000_0001, 4'h0, 1, 1, 0, 0, 1, 0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R8 flag reset", sts, 1'b0);
    chk("R8 irq reset", irq, 1'b0);
    rst = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule